// File: doc/BRIEF.md
# Debug Trigger Reentrancy Gate

This block sits beside the trigger comparators of a hart and decides, for every candidate trigger, whether a match may actually fire. Its purpose is to stop triggers that raise a breakpoint exception from firing again inside the handler that such an exception enters. Triggers with any other action, such as a halt into debug mode, are never held back.

The block is built in one of two forms, chosen by the `HAS_SMODE` parameter. With supervisor mode, an action-0 trigger is held back whenever the handler that would take the breakpoint has its interrupts disabled. That handler is found from the privilege level, the virtualization flag and the breakpoint bit of the two delegation registers. Without supervisor mode, the block holds a two-bit trigger-control register: an M-mode enable bit and a previous-enable bit. Trap entry pushes the enable bit into the previous-enable bit, and return from M-mode pops it back. Both outputs are combinational from the inputs and the register. The register changes only on the clock edge that follows a trap-entry pulse, a return pulse or a write.

Top module: `trig_fire_gate`

## Requirements
- R1: A trigger whose action code is nonzero has `fire_ok_o` = 1 and `mode_en_o` = 1 for every input pattern.
- R2: With supervisor mode, an action-0 trigger at privilege M (code 3) may fire exactly when `mie_i` is 1.
- R3: With supervisor mode, an action-0 trigger at privilege S (code 1) with `virt_i` = 0 may fire when `mdeleg_bp_i` = 0, and otherwise only when `sie_i` is 1.
- R4: With supervisor mode, an action-0 trigger at privilege S with `virt_i` = 1 may fire unless both `mdeleg_bp_i` and `hdeleg_bp_i` are 1, in which case it fires only when `vsie_i` is 1.
- R5: An action-0 trigger at privilege U (code 0) or at the unused code 2 is always allowed to fire, in both variants.
- R6: With supervisor mode, `ctl_rd_o` reads 2'b00 at all times; writes, trap entries and returns leave it at 0.
- R7: Without supervisor mode, `ctl_rd_o` (bit 0 = MTE, bit 1 = MPTE) is 2'b00 after reset, and `ctl_we_i` loads `ctl_wd_i` (same bit layout) on the next clock edge.
- R8: Without supervisor mode, an action-0 trigger at privilege M may fire exactly when MTE is 1; `virt_i`, `mie_i`, `sie_i`, `vsie_i` and both delegation bits have no effect.
- R9: A `trap_enter_i` pulse makes MPTE take the old MTE value and clears MTE on the next clock edge.
- R10: A `m_return_i` pulse sets both MTE and MPTE to the old MPTE value on the next clock edge.
- R11: `mode_en_o` of an action-0 trigger is 1 when the privilege is below M or MTE is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege: U=0, S=1, M=3 |
| virt_i | input | 1 | Hart runs virtualized |
| mie_i | input | 1 | Machine interrupt enable |
| sie_i | input | 1 | Supervisor interrupt enable |
| vsie_i | input | 1 | Virtual supervisor interrupt enable |
| mdeleg_bp_i | input | 1 | Breakpoint bit of machine exception delegation |
| hdeleg_bp_i | input | 1 | Breakpoint bit of hypervisor exception delegation |
| trap_enter_i | input | 1 | Single-cycle pulse: trap taken into M-mode |
| m_return_i | input | 1 | Single-cycle pulse: return from M-mode |
| ctl_we_i | input | 1 | Write strobe for the trigger-control register |
| ctl_wd_i | input | 2 | Write data, bit 0 = MTE, bit 1 = MPTE |
| act_i | input | NUM_TRIG*ACT_W | Action code per trigger, trigger i in bits [i*ACT_W +: ACT_W] |
| mode_en_o | output | NUM_TRIG | Mode-enable qualifier per trigger |
| fire_ok_o | output | NUM_TRIG | Fire permit per trigger |
| ctl_rd_o | output | 2 | Trigger-control register value, bit 0 = MTE, bit 1 = MPTE |

## Verification
The checker assumes that trap-entry and return pulses never arrive in the same cycle. It also assumes that the privilege and enable inputs change only between clock edges, so each sampled edge sees one stable pattern. The bench drives every input on the falling edge and raises at most one of the two pulses per cycle. It walks all privilege, virtualization, enable and delegation patterns against both variants, and it runs a nested trap-and-return sequence in which the enable bit is pushed and popped twice.

// File: rtl/trg_gate_pkg.sv
package trg_gate_pkg;
  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic mpte;
    logic mte;
  } tctl_t;

  typedef struct packed {
    logic virt;
    logic mie;
    logic sie;
    logic vsie;
    logic mdeleg_bp;
    logic hdeleg_bp;
  } gate_ctx_t;
endpackage

// File: rtl/trg_ctl_reg.sv
module trg_ctl_reg
  import trg_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_enter,
  input  logic  m_return,
  input  logic  wr_en,
  input  tctl_t wr_data,
  output tctl_t q
);
  generate
    if (HAS_SMODE) begin : g_absent
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, trap_enter, m_return, wr_en, wr_data};
      assign q = '0;
    end else begin : g_present
      tctl_t r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r <= '0;
        end else if (trap_enter) begin
          r.mpte <= r.mte;
          r.mte  <= 1'b0;
        end else if (m_return) begin
          r.mpte <= r.mpte;
          r.mte  <= r.mpte;
        end else if (wr_en) begin
          r <= wr_data;
        end
      end
      assign q = r;
    end
  endgenerate
endmodule

// File: rtl/trg_block_eval.sv
module trg_block_eval
  import trg_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  priv_e     priv,
  input  gate_ctx_t ctx,
  input  logic      mte,
  output logic      act0_block
);
  generate
    if (HAS_SMODE) begin : g_smode
      logic m_hold, s_hold, vs_hold;
      logic unused_mte;
      assign unused_mte = mte;
      always_comb begin
        m_hold  = (priv == PRV_M) && !ctx.mie;
        s_hold  = (priv == PRV_S) && !ctx.virt && ctx.mdeleg_bp && !ctx.sie;
        vs_hold = (priv == PRV_S) && ctx.virt && ctx.mdeleg_bp
                  && ctx.hdeleg_bp && !ctx.vsie;
        act0_block = m_hold || s_hold || vs_hold;
      end
    end else begin : g_mmode
      logic unused_ctx;
      assign unused_ctx = ^ctx;
      assign act0_block = (priv == PRV_M) && !mte;
    end
  endgenerate
endmodule

// File: rtl/trg_permit.sv
module trg_permit
  import trg_gate_pkg::*;
#(
  parameter int ACT_W = 4
) (
  input  logic [ACT_W-1:0] act,
  input  priv_e            priv,
  input  logic             mte,
  input  logic             act0_block,
  output logic             mode_en,
  output logic             fire_ok
);
  logic act_other;
  always_comb begin
    act_other = |act;
    mode_en   = (priv != PRV_M) || act_other || mte;
    fire_ok   = act_other || !act0_block;
  end
endmodule

// File: rtl/trig_fire_gate.sv
module trig_fire_gate
  import trg_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter int NUM_TRIG  = 4,
  parameter int ACT_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                priv_i,
  input  logic                      virt_i,
  input  logic                      mie_i,
  input  logic                      sie_i,
  input  logic                      vsie_i,
  input  logic                      mdeleg_bp_i,
  input  logic                      hdeleg_bp_i,
  input  logic                      trap_enter_i,
  input  logic                      m_return_i,
  input  logic                      ctl_we_i,
  input  logic [1:0]                ctl_wd_i,
  input  logic [NUM_TRIG*ACT_W-1:0] act_i,
  output logic [NUM_TRIG-1:0]       mode_en_o,
  output logic [NUM_TRIG-1:0]       fire_ok_o,
  output logic [1:0]                ctl_rd_o
);
  localparam int ACT_BITS = NUM_TRIG * ACT_W;

  priv_e     priv;
  gate_ctx_t ctx;
  tctl_t     ctl_q;
  tctl_t     ctl_wd;
  logic      act0_block;

  assign priv   = priv_e'(priv_i);
  assign ctl_wd = tctl_t'(ctl_wd_i);
  assign ctx    = '{virt: virt_i, mie: mie_i, sie: sie_i, vsie: vsie_i,
                    mdeleg_bp: mdeleg_bp_i, hdeleg_bp: hdeleg_bp_i};

  trg_ctl_reg #(.HAS_SMODE(HAS_SMODE)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_enter (trap_enter_i),
    .m_return   (m_return_i),
    .wr_en      (ctl_we_i),
    .wr_data    (ctl_wd),
    .q          (ctl_q)
  );

  trg_block_eval #(.HAS_SMODE(HAS_SMODE)) u_eval (
    .priv       (priv),
    .ctx        (ctx),
    .mte        (ctl_q.mte),
    .act0_block (act0_block)
  );

  generate
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
      trg_permit #(.ACT_W(ACT_W)) u_permit (
        .act        (act_i[i*ACT_W +: ACT_W]),
        .priv       (priv),
        .mte        (ctl_q.mte),
        .act0_block (act0_block),
        .mode_en    (mode_en_o[i]),
        .fire_ok    (fire_ok_o[i])
      );
    end
  endgenerate

  assign ctl_rd_o = ctl_q;

  if (ACT_BITS < 1) begin : g_bad_cfg
    initial $error("trig_fire_gate needs at least one action bit");
  end
endmodule

// File: rtl/trg_gate_chk.sv
module trg_gate_chk #(
  parameter bit HAS_SMODE = 1'b1,
  parameter int NUM_TRIG  = 4,
  parameter int ACT_W     = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                priv_i,
  input logic                      mie_i,
  input logic                      trap_enter_i,
  input logic                      m_return_i,
  input logic [NUM_TRIG*ACT_W-1:0] act_i,
  input logic [NUM_TRIG-1:0]       mode_en_o,
  input logic [NUM_TRIG-1:0]       fire_ok_o,
  input logic [1:0]                ctl_rd_o
);
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_enter_i && m_return_i)); // R9

  AST_TRAP_STACKS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter_i |=> (ctl_rd_o[0] == 1'b0) && (ctl_rd_o[1] == $past(ctl_rd_o[0]))); // R9

  AST_RETURN_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    m_return_i |=> (ctl_rd_o[0] == $past(ctl_rd_o[1])) && (ctl_rd_o[1] == $past(ctl_rd_o[1]))); // R10

  if (HAS_SMODE) begin : g_s
    AST_CTL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd_o == 2'b00); // R6
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_t
    AST_OTHER_ACT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[i*ACT_W +: ACT_W] != '0) |-> (fire_ok_o[i] && mode_en_o[i])); // R1
    AST_LOW_PRIV_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_i != 2'd3) |-> mode_en_o[i]); // R11
    if (HAS_SMODE) begin : g_sm
      AST_M_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_i == 2'd3) && (act_i[i*ACT_W +: ACT_W] == '0)) |-> (fire_ok_o[i] == mie_i)); // R2
    end else begin : g_nm
      AST_M_NEEDS_MTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_i == 2'd3) && (act_i[i*ACT_W +: ACT_W] == '0)) |-> (fire_ok_o[i] == ctl_rd_o[0])); // R8
    end
  end
endmodule

bind trig_fire_gate trg_gate_chk #(
  .HAS_SMODE (HAS_SMODE),
  .NUM_TRIG  (NUM_TRIG),
  .ACT_W     (ACT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .priv_i       (priv_i),
  .mie_i        (mie_i),
  .trap_enter_i (trap_enter_i),
  .m_return_i   (m_return_i),
  .act_i        (act_i),
  .mode_en_o    (mode_en_o),
  .fire_ok_o    (fire_ok_o),
  .ctl_rd_o     (ctl_rd_o)
);

// File: tb/tb_trig_fire_gate.sv
module tb_trig_fire_gate;
  localparam int NT = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] priv = 2'd0;
  logic virt = 0, mie = 0, sie = 0, vsie = 0, md = 0, hd = 0;
  logic trap = 0, mret = 0, we = 0;
  logic [1:0] wd = 2'b00;
  // trigger0 = 0, trigger1 = 1, trigger2 = 0, trigger3 = 15
  logic [NT*AW-1:0] act = {4'hF, 4'h0, 4'h1, 4'h0};
  logic [NT-1:0] men_s, fok_s, men_n, fok_n;
  logic [1:0] rd_s, rd_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_fire_gate #(.HAS_SMODE(1'b1), .NUM_TRIG(NT), .ACT_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt), .mie_i(mie),
    .sie_i(sie), .vsie_i(vsie), .mdeleg_bp_i(md), .hdeleg_bp_i(hd),
    .trap_enter_i(trap), .m_return_i(mret), .ctl_we_i(we), .ctl_wd_i(wd),
    .act_i(act), .mode_en_o(men_s), .fire_ok_o(fok_s), .ctl_rd_o(rd_s));

  trig_fire_gate #(.HAS_SMODE(1'b0), .NUM_TRIG(NT), .ACT_W(AW)) dut_nos (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt), .mie_i(mie),
    .sie_i(sie), .vsie_i(vsie), .mdeleg_bp_i(md), .hdeleg_bp_i(hd),
    .trap_enter_i(trap), .m_return_i(mret), .ctl_we_i(we), .ctl_wd_i(wd),
    .act_i(act), .mode_en_o(men_n), .fire_ok_o(fok_n), .ctl_rd_o(rd_n));

  // {priv[1:0], virt, mie, sie, vsie, mdeleg, hdeleg, exp_smode, exp_nosmode}, MTE = 0
  localparam logic [9:0] VEC [8] = '{
    10'b11_0_1_0_0_0_0_1_0,
    10'b11_0_0_1_1_1_1_0_0,
    10'b01_0_1_0_1_1_0_0_1,
    10'b01_0_0_1_0_1_0_1_1,
    10'b01_0_0_0_0_0_1_1_1,
    10'b01_1_1_1_0_1_1_0_1,
    10'b01_1_0_0_0_1_0_1_1,
    10'b00_0_0_0_0_1_1_1_1
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic ref_ok(bit sm, logic [1:0] p, logic v, logic m, logic s,
                                  logic vs, logic d1, logic d2, logic mte);
    if (sm)
      return !((p == 2'd3 && !m) || (p == 2'd1 && !v && d1 && !s) ||
               (p == 2'd1 && v && d1 && d2 && !vs));
    return !(p == 2'd3 && !mte);
  endfunction

  task automatic pulse(logic t, logic r, logic w, logic [1:0] d);
    @(negedge clk);
    trap = t; mret = r; we = w; wd = d;
    @(negedge clk);
    trap = 0; mret = 0; we = 0; wd = 2'b00;
    #1;
  endtask

  task automatic sweep(logic mte);
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      {priv, virt, mie, sie, vsie, md, hd} = c[7:0];
      #1;
      check("R2/R3/R4/R5 smode fire", fok_s[0],
            ref_ok(1, priv, virt, mie, sie, vsie, md, hd, 1'b0));
      check("R8/R5 nosmode fire", fok_n[2],
            ref_ok(0, priv, virt, mie, sie, vsie, md, hd, mte));
      check("R1 nonzero action", {fok_s[1], men_s[3], fok_n[3], men_n[1]}, 4'hF);
      check("R11 smode qual", men_s[0], priv != 2'd3);
      check("R11 nosmode qual", men_n[0], (priv != 2'd3) || mte);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 reset value", rd_n, 2'b00);
    check("R6 smode reads zero", rd_s, 2'b00);

    foreach (VEC[k]) begin
      @(negedge clk);
      {priv, virt, mie, sie, vsie, md, hd} = VEC[k][9:2];
      #1;
      check("R2/R3/R4 smode vector", fok_s[0], VEC[k][1]);
      check("R8 nosmode vector", fok_n[0], VEC[k][0]);
    end

    sweep(1'b0);
    pulse(0, 0, 1, 2'b01);
    check("R7 write loads", rd_n, 2'b01);
    check("R6 write ignored", rd_s, 2'b00);
    sweep(1'b1);

    // nested trap/return sequence on the variant with the register
    priv = 2'd3; mie = 0; sie = 0; vsie = 0; md = 1; hd = 1; virt = 1;
    pulse(1, 0, 0, 2'b00);
    check("R9 trap pushes", rd_n, 2'b10);
    check("R8 blocked after trap", fok_n[0], 1'b0);
    check("R11 qual after trap", men_n[0], 1'b0);
    check("R6 trap ignored", rd_s, 2'b00);
    pulse(0, 1, 0, 2'b00);
    check("R10 return restores", rd_n, 2'b11);
    check("R8 allowed after return", fok_n[0], 1'b1);
    pulse(1, 0, 0, 2'b00);
    check("R9 first nested trap", rd_n, 2'b10);
    pulse(1, 0, 0, 2'b00);
    check("R9 second nested trap", rd_n, 2'b00);
    pulse(0, 1, 0, 2'b00);
    check("R10 return with MPTE 0", rd_n, 2'b00);
    check("R6 return ignored", rd_s, 2'b00);
    pulse(0, 0, 1, 2'b10);
    pulse(0, 1, 0, 2'b00);
    check("R10 return from MPTE only", rd_n, 2'b11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule